// File: doc/BRIEF.md
# PHY Status Interrupt Controller

This block collects seven PHY status conditions into a sticky event register and drives an active-low interrupt request. Each condition has its own set edge and its own clear rules. The conditions are: energy present, autonegotiation done, remote fault, link loss, partner acknowledge, parallel-detect fault and page received. A mask register chooses which latched events may pull the interrupt pin low. The block sits behind the management register decoder. The decoder passes it one-cycle read strobes and write strobes, each with a 5-bit register address, and the block reacts to the addresses it owns.

The block has two clearing schemes, chosen by a level input. In the default scheme, a latched event is dropped by any of three things: the condition going away, a read of the event register, or a read of the related status register. In the alternate scheme, reads and source edges have no effect. Software clears an event by writing a one to it, and the clear takes effect only if the condition behind that event has already gone away.

Top module: `phy_irq_ctrl`

## Requirements
- R1: While rst_ni is low, flag_o reads 0x80 (energy event set), mask_o reads 0x00 and int_no is high.
- R2: The flag bit for each source is set one clock after its edge is sampled. Sources map to bits as follows: bit 7 energy, bit 6 autonegotiation done, bit 5 remote fault, bit 4 link status, bit 3 partner acknowledge, bit 2 parallel-detect fault, bit 1 page received. Bit 4 is set by a falling edge of link status. Every other bit is set by a rising edge of its source.
- R3: int_no is low exactly when some flag bit and the mask bit at the same position are both 1. Bit 0 of flag_o and mask_o always reads 0.
- R4: A write to address 30 loads wr_data_i[7:1] into mask bits 7..1, visible one clock later.
- R5: In default mode, a falling edge of a source clears its flag one clock later. The exception is bit 4, whose flag is unaffected when link status rises.
- R6: In default mode, a read of address 29 clears every flag one clock later.
- R7: In default mode, a read of address 1 clears bits 5 and 4, and a read of address 6 clears bits 2 and 1. Other flags are unaffected, and reads of other addresses clear nothing.
- R8: In default mode, an an_restart_i pulse or a falling edge of link status clears bits 2 and 1.
- R9: In default mode, writes to address 29 leave the flags unchanged.
- R10: In alternate mode (alt_mode_i=1), source falling edges and register reads leave the flags unchanged.
- R11: In alternate mode, writing a 1 to a flag bit at address 29 clears it one clock later only if the source is then inactive (low, or high for link status). Otherwise the flag stays set.
- R12: A set event in the same cycle as a clear of the same bit leaves the bit set.
- R13: The energy source is taken as present at reset. After reset is released with the source low, flag bit 7 clears one clock later in default mode. If the source is high at release, the bit stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| alt_mode_i | input | 1 | 1 selects write-one clearing |
| src_i | input | 7 | Live source levels, index matches flag bit (7:1) |
| an_restart_i | input | 1 | Autonegotiation restart pulse |
| rd_i | input | 1 | Register read strobe |
| rd_addr_i | input | 5 | Read address |
| wr_i | input | 1 | Register write strobe |
| wr_addr_i | input | 5 | Write address |
| wr_data_i | input | 7 | Write data bits 7:1 |
| flag_o | output | 8 | Event flag register |
| mask_o | output | 8 | Mask register |
| int_no | output | 1 | Interrupt request, active low |

## Verification
A flag that latches on the wrong edge or misses a clear shows on flag_o one clock after the offending strobe or edge. Because the pin is combinational from the two registers, int_no shows the same fault in that same clock whenever the mask bit is set. A stuck mode selection surfaces at the first read or write-one that should behave differently between the two schemes. The stimulus therefore crosses both modes with held and released sources, so every clear path is taken both with its condition true and with it false.

// File: rtl/phy_irq_pkg.sv
package phy_irq_pkg;
  localparam int NUM_SRC = 7;
  localparam int REG_W   = NUM_SRC + 1;
  localparam int ADDR_W  = 5;

  // register bit positions; decoded by software, kept fixed
  localparam int B_ENERGY = 7;
  localparam int B_ANDONE = 6;
  localparam int B_RFAULT = 5;
  localparam int B_LINK   = 4;
  localparam int B_LPACK  = 3;
  localparam int B_PDF    = 2;
  localparam int B_PAGE   = 1;

  localparam logic [REG_W-1:0] STAT_CLR = REG_W'((1 << B_RFAULT) | (1 << B_LINK));
  localparam logic [REG_W-1:0] EXP_CLR  = REG_W'((1 << B_PDF) | (1 << B_PAGE));
  localparam logic [REG_W-1:0] AN_CLR   = EXP_CLR;
  localparam logic [REG_W-1:0] FALL_CLR = ~REG_W'((1 << B_LINK) | 1);
  localparam logic [REG_W-1:0] FLAG_RST = REG_W'(1 << B_ENERGY);
  localparam logic [REG_W-1:0] SRC_RST  = REG_W'(1 << B_ENERGY);
endpackage

// File: rtl/phy_irq_edge.sv
module phy_irq_edge #(
  parameter int             W       = 7,
  parameter logic [W-1:0]   RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] lvl_i,
  output logic [W-1:0] rise_o,
  output logic [W-1:0] fall_o
);
  logic [W-1:0] lvl_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) lvl_q <= RST_VAL;
    else         lvl_q <= lvl_i;
  end

  assign rise_o = lvl_i & ~lvl_q;
  assign fall_o = ~lvl_i & lvl_q;
endmodule

// File: rtl/phy_irq_flags.sv
module phy_irq_flags #(
  parameter int             W   = 8,
  parameter logic [W-1:0]   RST = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         alt_i,
  input  logic [W-1:1] set_i,
  input  logic [W-1:1] clr_i,
  input  logic [W-1:1] w1c_i,
  input  logic [W-1:1] gone_i,
  output logic [W-1:1] flag_o
);
  for (genvar b = 1; b < W; b++) begin : g_bit
    logic q;
    logic kill;

    assign kill = alt_i ? (w1c_i[b] & gone_i[b]) : clr_i[b];

    // set dominates clear
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) q <= RST[b];
      else         q <= set_i[b] | (q & ~kill);
    end

    assign flag_o[b] = q;

    p_event_sets_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
      set_i[b] |=> flag_o[b]);
    p_alt_sticky_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      alt_i && flag_o[b] && !w1c_i[b] |=> flag_o[b]);
    p_alt_keep_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
      alt_i && flag_o[b] && w1c_i[b] && !gone_i[b] |=> flag_o[b]);
    p_alt_clear_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
      alt_i && w1c_i[b] && gone_i[b] && !set_i[b] |=> !flag_o[b]);
    p_def_clear_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !alt_i && clr_i[b] && !set_i[b] |=> !flag_o[b]);
  end
endmodule

// File: rtl/phy_irq_mask.sv
module phy_irq_mask #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         we_i,
  input  logic [W-1:1] d_i,
  output logic [W-1:1] mask_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   mask_o <= '0;
    else if (we_i) mask_o <= d_i;
  end

  p_mask_load_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |=> mask_o == $past(d_i));
  p_mask_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_i |=> $stable(mask_o));
endmodule

// File: rtl/phy_irq_ctrl.sv
module phy_irq_ctrl
  import phy_irq_pkg::*;
#(
  parameter logic [ADDR_W-1:0] FLAG_ADDR = 5'd29,
  parameter logic [ADDR_W-1:0] MASK_ADDR = 5'd30,
  parameter logic [ADDR_W-1:0] STAT_ADDR = 5'd1,
  parameter logic [ADDR_W-1:0] EXP_ADDR  = 5'd6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              alt_mode_i,
  input  logic [REG_W-1:1]  src_i,
  input  logic              an_restart_i,
  input  logic              rd_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [REG_W-1:1]  wr_data_i,
  output logic [REG_W-1:0]  flag_o,
  output logic [REG_W-1:0]  mask_o,
  output logic              int_no
);
  logic [REG_W-1:1] rise, fall, ev, gone, clr, w1c, flag_q, mask_q;
  logic rd_flag, rd_stat, rd_exp, wr_flag, wr_mask;

  assign rd_flag = rd_i && (rd_addr_i == FLAG_ADDR);
  assign rd_stat = rd_i && (rd_addr_i == STAT_ADDR);
  assign rd_exp  = rd_i && (rd_addr_i == EXP_ADDR);
  assign wr_flag = wr_i && (wr_addr_i == FLAG_ADDR);
  assign wr_mask = wr_i && (wr_addr_i == MASK_ADDR);

  phy_irq_edge #(
    .W       (NUM_SRC),
    .RST_VAL (SRC_RST[REG_W-1:1])
  ) u_edge (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .lvl_i  (src_i),
    .rise_o (rise),
    .fall_o (fall)
  );

  for (genvar b = 1; b < REG_W; b++) begin : g_src
    localparam bit ACT_LOW = (b == B_LINK);
    assign ev[b]   = ACT_LOW ? fall[b] : rise[b];
    assign gone[b] = ACT_LOW ? src_i[b] : ~src_i[b];
    assign clr[b]  = (FALL_CLR[b] & fall[b])
                   | rd_flag
                   | (STAT_CLR[b] & rd_stat)
                   | (EXP_CLR[b] & rd_exp)
                   | (AN_CLR[b] & (an_restart_i | fall[B_LINK]));
  end

  assign w1c = {NUM_SRC{wr_flag}} & wr_data_i;

  phy_irq_flags #(
    .W   (REG_W),
    .RST (FLAG_RST)
  ) u_flags (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .alt_i  (alt_mode_i),
    .set_i  (ev),
    .clr_i  (clr),
    .w1c_i  (w1c),
    .gone_i (gone),
    .flag_o (flag_q)
  );

  phy_irq_mask #(
    .W (REG_W)
  ) u_mask (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .we_i   (wr_mask),
    .d_i    (wr_data_i),
    .mask_o (mask_q)
  );

  assign flag_o = {flag_q, 1'b0};
  assign mask_o = {mask_q, 1'b0};
  assign int_no = ~|(flag_q & mask_q);

  p_link_drop_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !alt_mode_i && fall[B_LINK] && !ev[B_PDF] && !ev[B_PAGE]
    |=> !flag_o[B_PDF] && !flag_o[B_PAGE]);
  p_link_set_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fall[B_LINK] |=> flag_o[B_LINK]);
endmodule

// File: tb/phy_irq_ctrl_bench.sv
module phy_irq_ctrl_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 33;
  localparam logic [1:0] OP_N = 2'd0, OP_RD = 2'd1, OP_WR = 2'd2, OP_RS = 2'd3;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic alt_mode_i = 1'b0;
  logic [7:1] src_i = 7'b0001000;
  logic an_restart_i = 1'b0;
  logic rd_i = 1'b0;
  logic [4:0] rd_addr_i = '0;
  logic wr_i = 1'b0;
  logic [4:0] wr_addr_i = '0;
  logic [7:1] wr_data_i = '0;
  logic [7:0] flag_o, mask_o;
  logic int_no;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  phy_irq_ctrl u_phy_irq_ctrl (
    .clk_i(clk_i), .rst_ni(rst_ni), .alt_mode_i(alt_mode_i), .src_i(src_i),
    .an_restart_i(an_restart_i), .rd_i(rd_i), .rd_addr_i(rd_addr_i),
    .wr_i(wr_i), .wr_addr_i(wr_addr_i), .wr_data_i(wr_data_i),
    .flag_o(flag_o), .mask_o(mask_o), .int_no(int_no)
  );

  // req, src[7:1], alt, op, addr, data, exp flag, exp mask, exp int_no
  function automatic logic [43:0] v(input logic [3:0] r, input logic [6:0] s,
      input logic a, input logic [1:0] op, input logic [4:0] ad, input logic [7:0] d,
      input logic [7:0] ef, input logic [7:0] em, input logic en);
    return {r, s, a, op, ad, d, ef, em, en};
  endfunction

  localparam logic [43:0] TBL [NV] = '{
    v(13, 7'b0001000, 0, OP_N,  0, 8'h00, 8'h00, 8'h00, 1), // R13 energy low at release
    v(4,  7'b0001000, 0, OP_WR, 30, 8'hFF, 8'h00, 8'hFE, 1), // R4 mask write
    v(2,  7'b0101000, 0, OP_N,  0, 8'h00, 8'h40, 8'hFE, 0), // R2 andone rise
    v(2,  7'b0101000, 0, OP_N,  0, 8'h00, 8'h40, 8'hFE, 0),
    v(5,  7'b0001000, 0, OP_N,  0, 8'h00, 8'h00, 8'hFE, 1), // R5 fall clears
    v(2,  7'b0011000, 0, OP_N,  0, 8'h00, 8'h20, 8'hFE, 0), // rfault rise
    v(7,  7'b0011000, 0, OP_RD, 6, 8'h00, 8'h20, 8'hFE, 0), // R7 exp read spares bit 5
    v(7,  7'b0011000, 0, OP_RD, 1, 8'h00, 8'h00, 8'hFE, 1), // R7 status read
    v(2,  7'b0010000, 0, OP_N,  0, 8'h00, 8'h10, 8'hFE, 0), // link fall sets bit 4
    v(5,  7'b0011000, 0, OP_N,  0, 8'h00, 8'h10, 8'hFE, 0), // R5 link rise no clear
    v(2,  7'b0011011, 0, OP_N,  0, 8'h00, 8'h16, 8'hFE, 0),
    v(7,  7'b0011011, 0, OP_RD, 1, 8'h00, 8'h06, 8'hFE, 0),
    v(8,  7'b0011011, 0, OP_RS, 0, 8'h00, 8'h00, 8'hFE, 1), // R8 restart
    v(5,  7'b0011000, 0, OP_N,  0, 8'h00, 8'h00, 8'hFE, 1),
    v(2,  7'b0011011, 0, OP_N,  0, 8'h00, 8'h06, 8'hFE, 0),
    v(8,  7'b0010011, 0, OP_N,  0, 8'h00, 8'h10, 8'hFE, 0), // R8 link down
    v(5,  7'b0011011, 0, OP_N,  0, 8'h00, 8'h10, 8'hFE, 0),
    v(9,  7'b0011011, 0, OP_WR, 29, 8'hFF, 8'h10, 8'hFE, 0), // R9 write ignored
    v(6,  7'b0011011, 0, OP_RD, 29, 8'h00, 8'h00, 8'hFE, 1), // R6 flag read
    v(2,  7'b1011111, 0, OP_N,  0, 8'h00, 8'h88, 8'hFE, 0),
    v(12, 7'b1111111, 0, OP_RD, 29, 8'h00, 8'h40, 8'hFE, 0), // R12 set beats read
    v(3,  7'b1111111, 0, OP_WR, 30, 8'h00, 8'h40, 8'h00, 1), // R3 masked
    v(3,  7'b1111111, 0, OP_WR, 30, 8'hFF, 8'h40, 8'hFE, 0),
    v(10, 7'b1111111, 1, OP_N,  0, 8'h00, 8'h40, 8'hFE, 0), // R10 alt mode
    v(10, 7'b1011111, 1, OP_N,  0, 8'h00, 8'h40, 8'hFE, 0),
    v(10, 7'b1011111, 1, OP_RD, 29, 8'h00, 8'h40, 8'hFE, 0),
    v(11, 7'b1011111, 1, OP_WR, 29, 8'h40, 8'h00, 8'hFE, 1), // R11 clear, source gone
    v(2,  7'b1111111, 1, OP_N,  0, 8'h00, 8'h40, 8'hFE, 0),
    v(11, 7'b1111111, 1, OP_WR, 29, 8'h40, 8'h40, 8'hFE, 0), // R11 source still on
    v(3,  7'b1111111, 1, OP_WR, 30, 8'hBE, 8'h40, 8'hBE, 1),
    v(2,  7'b1110111, 1, OP_N,  0, 8'h00, 8'h50, 8'hBE, 0),
    v(11, 7'b1110111, 1, OP_WR, 29, 8'h10, 8'h50, 8'hBE, 0), // R11 link still down
    v(11, 7'b1111111, 1, OP_WR, 29, 8'h10, 8'h40, 8'hBE, 1)  // R11 link back up
  };

  task automatic chk(input string tag, input string what, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic drive(input logic [6:0] s, input logic a, input logic [1:0] op,
                       input logic [4:0] ad, input logic [7:0] d);
    src_i = s; alt_mode_i = a;
    rd_i = (op == OP_RD); rd_addr_i = ad;
    wr_i = (op == OP_WR); wr_addr_i = ad; wr_data_i = d[7:1];
    an_restart_i = (op == OP_RS);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    chk("R1", "flag", flag_o, 8'h80);
    chk("R1", "mask", mask_o, 8'h00);
    chk("R1", "int_no", {7'd0, int_no}, 8'h01);
    rst_ni = 1'b1;
    for (int i = 0; i < NV; i++) begin
      logic [43:0] e;
      string tag;
      e = TBL[i];
      tag = $sformatf("R%0d/step%0d", e[43:40], i);
      drive(e[39:33], e[32], e[31:30], e[29:25], e[24:17]);
      @(negedge clk_i);
      chk(tag, "flag", flag_o, e[16:9]);
      chk(tag, "mask", mask_o, e[8:1]);
      chk(tag, "int_no", {7'd0, int_no}, {7'd0, e[0]});
    end
    // R13: energy high through reset keeps bit 7
    drive(7'b1001000, 0, OP_N, 0, 8'h00);
    rst_ni = 1'b0;
    repeat (2) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk("R13", "flag", flag_o, 8'h80);
    chk("R1", "mask", mask_o, 8'h00);
    // R7: read of an unrelated address clears nothing
    drive(7'b1001000, 0, OP_RD, 5'd2, 8'h00);
    @(negedge clk_i);
    chk("R7", "flag", flag_o, 8'h80);
    drive(7'b1001000, 0, OP_RD, 5'd29, 8'h00);
    @(negedge clk_i);
    chk("R6", "flag", flag_o, 8'h00);
    drive(7'b1001000, 0, OP_N, 0, 8'h00);
    @(negedge clk_i);
    chk("R3", "int_no", {7'd0, int_no}, 8'h01);
    finish_run();
  end

  initial begin
    repeat (5000) @(posedge clk_i);
    checks++;
    failures++;
    $display("FAIL watchdog expired");
    finish_run();
  end
endmodule